// File: doc/BRIEF.md
# Stepped Clock Enable Generator

This block turns a fixed 100 MHz reference clock into a single-cycle clock-enable stream for a protected logic region. The region runs from the reference clock and advances only in cycles where the enable is high, so its effective rate is a fraction of the reference. The rate is chosen by a code N (2..20). The region then sees N active cycles in every 20 reference cycles, which gives 10 MHz to 100 MHz in 5 MHz steps. All logic stays in one synchronous clock domain, and no second clock is generated.

A modulo-20 phase accumulator adds the current code every reference cycle and pulses when it wraps, so the enables are spread evenly. A new code is applied only at a wrap, so pulse spacing never breaks in the middle of a period. A gate request stops all enables, leaving only static power. While the gate is held, the accumulator phase and the current code are kept. In stepping mode the block walks the rate up or down by one step at fixed dwell intervals. The direction of each step comes from a 16-bit LFSR that is stirred by an external entropy bit. This moves the power signature of the region over time.

Top module: `step_clk_en_gen`

## Requirements
- R1: After reset, `clk_en_o` is 0 and `rate_code_o` is 20 (full rate).
- R2: With the code held at N and no gating, `clk_en_o` is high exactly N times in every 20 consecutive cycles. The gap between consecutive enables is never longer than ceil(20/N) cycles.
- R3: A requested code below 2 is treated as 2, and a requested code above 20 is treated as 20. The code is a 5-bit unsigned number.
- R4: A new code takes effect only on an accumulator wrap. `rate_code_o` changes only in a cycle where `clk_en_o` is also high. A change of `rate_code_i` appears at the output at the first wrap that comes at least two edges after it is sampled.
- R5: The gate request is registered. If `gate_req_i` is sampled high at edge k, `clk_en_o` is low in every cycle that follows edge k+1 for as long as the request stays high. While gated, the accumulator phase is frozen. After release the enables resume from that phase with no extra or lost pulse.
- R6: `rate_code_o` does not change while gating is in effect, even if `rate_code_i` changes.
- R7: In stepping mode (`step_mode_i` = 1), a dwell counter expires once every 64 cycles. At each expiry the target code moves up by one if LFSR bit 0 is 1, and down by one if it is 0. The target saturates at 2 and at 20, and it reaches the output at the next wrap. Outside stepping mode the dwell counter is held at 0.
- R8: The LFSR resets to 0xACE1 and shifts left every cycle. The new bit 0 is the XOR of bits 15, 13, 12 and 10 and `entropy_i`. An all-zero state reloads 0xACE1.
- R9: `rate_code_o` always lies between 2 and 20 inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (100 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code_i | input | 5 | Requested rate code N; the effective rate is N x 5 MHz |
| gate_req_i | input | 1 | When high, stops all enables |
| step_mode_i | input | 1 | Selects randomised up/down stepping in place of `rate_code_i` |
| entropy_i | input | 1 | Random bit that is mixed into the LFSR feedback |
| clk_en_o | output | 1 | Single-cycle enable for the protected region |
| rate_code_o | output | 5 | Code currently in effect |

## Verification
The two functions most likely to meet in one cycle are a gate transition and an accumulator wrap that also loads a new code. The bench sweeps gate pulses across all twenty phase offsets and changes `rate_code_i` in the same cycle as each gate edge. A cycle-accurate reference model then decides, on every clock, whether that wrap's pulse and code update should appear or be held back. A second collision, a dwell expiry on the same edge as a wrap, arises naturally during long stepping runs and is judged by the same model.

// File: rtl/sce_pkg.sv
package sce_pkg;
    localparam int unsigned SCE_STEPS_DEF = 20;
    localparam int unsigned SCE_MIN_DEF   = 2;
    localparam int unsigned SCE_DWELL_DEF = 64;
    localparam int unsigned SCE_LFSR_W    = 16;
    localparam logic [15:0] SCE_SEED_DEF  = 16'hACE1;
    localparam logic [15:0] SCE_TAPS_DEF  = 16'hB400;

    typedef enum logic {
        STEP_DOWN = 1'b0,
        STEP_UP   = 1'b1
    } step_dir_e;
endpackage

// File: rtl/sce_lfsr.sv
module sce_lfsr #(
    parameter int unsigned W     = sce_pkg::SCE_LFSR_W,
    parameter logic [W-1:0] SEED = W'(sce_pkg::SCE_SEED_DEF),
    parameter logic [W-1:0] TAPS = W'(sce_pkg::SCE_TAPS_DEF)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         entropy_i,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } lfsr_st_t;

    lfsr_st_t s_d, s_q;
    logic     fb;

    always_comb begin
        s_d = s_q;
        fb  = (^(s_q.sr & TAPS)) ^ entropy_i;
        if (s_q.sr == '0) begin
            s_d.sr = SEED;
        end else begin
            s_d.sr = {s_q.sr[W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.sr <= SEED;
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o = s_q.sr;
endmodule

// File: rtl/sce_stepper.sv
module sce_stepper #(
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned MIN_CODE  = 2,
    parameter int unsigned MAX_CODE  = 20,
    parameter int unsigned DWELL_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_mode_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              coin_i,
    output logic [CODE_W-1:0] target_o
);
    import sce_pkg::*;

    localparam int unsigned CNT_W = (DWELL_CYC > 2) ? $clog2(DWELL_CYC) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DWELL_CYC - 1);
    localparam logic [CODE_W-1:0] LO       = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] HI       = CODE_W'(MAX_CODE);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] tgt;
    } step_st_t;

    step_st_t  s_d, s_q;
    step_dir_e dir;

    always_comb begin
        s_d = s_q;
        dir = coin_i ? STEP_UP : STEP_DOWN;
        if (step_mode_i) begin
            if (s_q.cnt == CNT_LAST) begin
                s_d.cnt = '0;
                if (dir == STEP_UP) begin
                    s_d.tgt = (s_q.tgt >= HI) ? HI : s_q.tgt + 1'b1;
                end else begin
                    s_d.tgt = (s_q.tgt <= LO) ? LO : s_q.tgt - 1'b1;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else begin
            s_d.cnt = '0;
            s_d.tgt = code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.tgt <= HI;
        end else begin
            s_q <= s_d;
        end
    end

    assign target_o = s_q.tgt;
endmodule

// File: rtl/sce_accum.sv
module sce_accum #(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned STEPS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_req_i,
    input  logic [CODE_W-1:0] target_i,
    output logic              en_o,
    output logic [CODE_W-1:0] rate_o
);
    localparam int unsigned ACC_W = (STEPS > 2) ? $clog2(STEPS) : 1;
    localparam int unsigned SUM_W = CODE_W + 1;
    localparam logic [SUM_W-1:0]  MOD_S = SUM_W'(STEPS);
    localparam logic [CODE_W-1:0] FULL  = CODE_W'(STEPS);

    typedef struct packed {
        logic              gate;
        logic [ACC_W-1:0]  acc;
        logic [CODE_W-1:0] cur;
        logic              pulse;
    } acc_st_t;

    acc_st_t          s_d, s_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        s_d       = s_q;
        s_d.gate  = gate_req_i;
        s_d.pulse = 1'b0;
        sum       = SUM_W'(s_q.acc) + SUM_W'(s_q.cur);
        if (!s_q.gate) begin
            if (sum >= MOD_S) begin
                s_d.acc   = ACC_W'(sum - MOD_S);
                s_d.pulse = 1'b1;
                s_d.cur   = target_i;
            end else begin
                s_d.acc = ACC_W'(sum);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.gate  <= 1'b0;
            s_q.acc   <= '0;
            s_q.cur   <= FULL;
            s_q.pulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o   = s_q.pulse;
    assign rate_o = s_q.cur;
endmodule

// File: rtl/step_clk_en_gen.sv
module step_clk_en_gen #(
    parameter int unsigned STEPS     = sce_pkg::SCE_STEPS_DEF,
    parameter int unsigned MIN_CODE  = sce_pkg::SCE_MIN_DEF,
    parameter int unsigned DWELL_CYC = sce_pkg::SCE_DWELL_DEF,
    parameter int unsigned CODE_W    = $clog2(STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rate_code_i,
    input  logic              gate_req_i,
    input  logic              step_mode_i,
    input  logic              entropy_i,
    output logic              clk_en_o,
    output logic [CODE_W-1:0] rate_code_o
);
    import sce_pkg::*;

    localparam logic [CODE_W-1:0] LO = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] HI = CODE_W'(STEPS);

    logic [CODE_W-1:0]     code_clamped;
    logic [CODE_W-1:0]     target;
    logic [SCE_LFSR_W-1:0] lfsr_state;

    always_comb begin
        if (rate_code_i < LO) begin
            code_clamped = LO;
        end else if (rate_code_i > HI) begin
            code_clamped = HI;
        end else begin
            code_clamped = rate_code_i;
        end
    end

    sce_lfsr #(
        .W    (SCE_LFSR_W),
        .SEED (SCE_SEED_DEF),
        .TAPS (SCE_TAPS_DEF)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .entropy_i (entropy_i),
        .state_o   (lfsr_state)
    );

    sce_stepper #(
        .CODE_W    (CODE_W),
        .MIN_CODE  (MIN_CODE),
        .MAX_CODE  (STEPS),
        .DWELL_CYC (DWELL_CYC)
    ) u_stepper (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_mode_i (step_mode_i),
        .code_i      (code_clamped),
        .coin_i      (lfsr_state[0]),
        .target_o    (target)
    );

    sce_accum #(
        .CODE_W (CODE_W),
        .STEPS  (STEPS)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_req_i (gate_req_i),
        .target_i   (target),
        .en_o       (clk_en_o),
        .rate_o     (rate_code_o)
    );
endmodule

// File: rtl/sce_checker.sv
module sce_checker #(
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned MIN_CODE = 2,
    parameter int unsigned MAX_CODE = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gate_req_i,
    input logic              clk_en_o,
    input logic [CODE_W-1:0] rate_code_o
);
    p_code_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code_o >= CODE_W'(MIN_CODE)) && (rate_code_o <= CODE_W'(MAX_CODE)));

    p_change_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code_o != $past(rate_code_o)) |-> clk_en_o);

    p_gate_silences_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_req_i, 2) |-> !clk_en_o);

    p_code_frozen_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_req_i, 2) |-> $stable(rate_code_o));
endmodule

bind step_clk_en_gen sce_checker #(
    .CODE_W   (CODE_W),
    .MIN_CODE (MIN_CODE),
    .MAX_CODE (STEPS)
) u_sce_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_req_i  (gate_req_i),
    .clk_en_o    (clk_en_o),
    .rate_code_o (rate_code_o)
);

// File: tb/tb_step_clk_en_gen.sv
module tb_step_clk_en_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rate_code_i = 5'd20;
    logic       gate_req_i = 1'b0;
    logic       step_mode_i = 1'b0;
    logic       entropy_i = 1'b0;
    logic       clk_en_o;
    logic [4:0] rate_code_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 1'b0;
    string phase_req = "R1";

    always #2 clk = ~clk;

    step_clk_en_gen dut (
        .clk(clk), .rst_n(rst_n), .rate_code_i(rate_code_i), .gate_req_i(gate_req_i),
        .step_mode_i(step_mode_i), .entropy_i(entropy_i),
        .clk_en_o(clk_en_o), .rate_code_o(rate_code_o)
    );

    // behavioural reference model
    int m_acc, m_cur, m_tgt, m_cnt;
    bit m_gate, m_pulse;
    bit [15:0] m_lfsr;

    function automatic int clampc(int c);
        if (c < 2) return 2;
        if (c > 20) return 20;
        return c;
    endfunction

    always @(posedge clk) begin
        int s, n_acc, n_cur, n_tgt, n_cnt;
        bit wrap, fb;
        bit [15:0] n_lfsr;
        if (!rst_n) begin
            m_acc <= 0; m_cur <= 20; m_tgt <= 20; m_cnt <= 0;
            m_gate <= 0; m_pulse <= 0; m_lfsr <= 16'hACE1;
        end else begin
            wrap = 0; n_acc = m_acc;
            if (!m_gate) begin
                s = m_acc + m_cur;
                if (s >= 20) begin wrap = 1; n_acc = s - 20; end else n_acc = s;
            end
            n_cur = wrap ? m_tgt : m_cur;
            fb = m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10] ^ entropy_i;
            n_lfsr = (m_lfsr == 0) ? 16'hACE1 : {m_lfsr[14:0], fb};
            n_tgt = m_tgt; n_cnt = 0;
            if (step_mode_i) begin
                if (m_cnt == 63) begin
                    n_cnt = 0;
                    n_tgt = m_lfsr[0] ? ((m_tgt + 1 > 20) ? 20 : m_tgt + 1)
                                      : ((m_tgt - 1 < 2) ? 2 : m_tgt - 1);
                end else n_cnt = m_cnt + 1;
            end else n_tgt = clampc(int'(rate_code_i));
            m_acc <= n_acc; m_cur <= n_cur; m_tgt <= n_tgt; m_cnt <= n_cnt;
            m_gate <= gate_req_i; m_pulse <= wrap; m_lfsr <= n_lfsr;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(clk_en_o == m_pulse, {phase_req, " enable"}, clk_en_o, m_pulse);
            chk(int'(rate_code_o) == m_cur, {phase_req, " code"}, rate_code_o, m_cur);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            done = 1'b1;
            mismatched++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: count enables over 40 cycles, check spacing
    task automatic rate_window(int req_code, int eff);
        int cnt = 0, gap = 0, maxgap = 0, first = 1;
        @(negedge clk); rate_code_i = 5'(req_code);
        wait_cyc(60);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            gap++;
            if (clk_en_o) begin
                cnt++;
                if (!first && gap > maxgap) maxgap = gap;
                first = 0; gap = 0;
            end
        end
        chk(cnt == 2 * eff, "R2 enable count", cnt, 2 * eff);
        chk(maxgap <= (20 + eff - 1) / eff, "R2 spacing", maxgap, (20 + eff - 1) / eff);
        chk(int'(rate_code_o) == eff, "R3 clamped code", rate_code_o, eff);
    endtask

    initial begin
        int hold, ens, changes, prev, badstep;
        wait_cyc(5);
        rst_n = 1'b1;
        #1;
        chk(clk_en_o == 1'b0, "R1 reset enable", clk_en_o, 0);
        chk(rate_code_o == 5'd20, "R1 reset code", rate_code_o, 20);

        phase_req = "R2";
        rate_window(20, 20);
        rate_window(7, 7);
        rate_window(2, 2);
        rate_window(13, 13);
        phase_req = "R3";
        rate_window(0, 2);
        rate_window(31, 20);
        rate_window(1, 2);

        // R4: change lands only at a wrap
        phase_req = "R4";
        rate_window(5, 5);
        @(negedge clk); rate_code_i = 5'd17;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rate_code_o == 5'd17) begin
                chk(clk_en_o == 1'b1, "R4 update with enable", clk_en_o, 1);
                break;
            end
        end

        // R5/R6: long gate with code change inside
        phase_req = "R5";
        @(negedge clk); gate_req_i = 1'b1;
        wait_cyc(2);
        hold = rate_code_o; ens = 0;
        @(negedge clk); rate_code_i = 5'd3;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (clk_en_o) ens++;
            if (int'(rate_code_o) != hold) chk(0, "R6 code frozen", rate_code_o, hold);
        end
        chk(ens == 0, "R5 gated enables", ens, 0);
        chk(int'(rate_code_o) == hold, "R6 code held", rate_code_o, hold);
        @(negedge clk); gate_req_i = 1'b0;
        rate_window(3, 3);

        // collision sweep: gate edges and code changes at every phase
        phase_req = "R5";
        rate_window(9, 9);
        for (int off = 0; off < 20; off++) begin
            wait_cyc(off + 1);
            gate_req_i = 1'b1; rate_code_i = 5'(2 + (off % 19));
            wait_cyc(off % 5 + 1);
            gate_req_i = 1'b0; rate_code_i = 5'(20 - (off % 7));
        end

        // R7/R8: stepping mode with random entropy
        phase_req = "R7";
        @(negedge clk); step_mode_i = 1'b1;
        changes = 0; badstep = 0; prev = rate_code_o;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            entropy_i = 1'($urandom);
            if (int'(rate_code_o) != prev) begin
                changes++;
                if (int'(rate_code_o) - prev != 1 && prev - int'(rate_code_o) != 1) badstep++;
                prev = rate_code_o;
            end
            if (rate_code_o < 5'd2 || rate_code_o > 5'd20) chk(0, "R9 range", rate_code_o, 2);
        end
        chk(changes > 0, "R7 code moves", changes, 1);
        chk(badstep == 0, "R7 unit steps", badstep, 0);
        phase_req = "R8";
        @(negedge clk); gate_req_i = 1'b1;
        wait_cyc(100);
        @(negedge clk); gate_req_i = 1'b0;
        wait_cyc(300);
        step_mode_i = 1'b0; rate_code_i = 5'd11;
        phase_req = "R9";
        wait_cyc(40);
        chk(rate_code_o == 5'd11, "R9 return to fixed code", rate_code_o, 11);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule